// File: doc/BRIEF.md
# LPC Peripheral Cycle Responder

This block sits on the peripheral side of a Low Pin Count bus. It watches the 4-bit multiplexed LAD bus and the active-low frame strobe, and recognises I/O and DMA cycles that begin with a 0000 start nibble. It gathers the cycle type, address or channel, transfer size and host write data. After the host turnaround it takes the bus, drives wait and SYNC nibbles, returns read data, and hands the bus back with a two-clock turnaround. The DMA request output stays inactive (high) at all times.

Each byte is offered to the register side as one transaction on a valid/ready pair. `txn_valid` rises in the first SYNC clock. The payload (`txn_write`, `txn_dma`, `txn_addr`, `txn_idx`, `txn_wdata`) stays stable while `txn_valid` is high and `txn_ready` is low. The register side accepts a byte by raising `txn_ready`, and in that same clock it presents `rsp_rdata` and `rsp_err`. It may hold back `txn_ready` for as long as it likes. The block does not wait forever, though: when the fixed wait runs out, it withdraws `txn_valid` and ends the byte with an error SYNC. This happens unless `rsp_long` is held high, in which case the block keeps waiting up to a cap of 330 SYNC clocks. A frame-strobe abort also withdraws `txn_valid`.

Top module: `lpc_target`

## Requirements
- R1: A cycle begins only when the frame strobe is low and LAD carries 0000 at the same clock edge. A low strobe with any other nibble leaves the block idle, and it never drives LAD.
- R2: The nibble after START is the cycle type. In bits 3:2, 00 selects I/O, 10 selects DMA, and any other value makes the block ignore the cycle. Bit 1 set means the host writes. Bit 0 is ignored. The I/O address follows as four nibbles, most significant first. A DMA cycle instead sends one channel nibble (presented as `txn_addr`, zero-extended) and one size nibble. Data bytes move low nibble first.
- R3: When the register side has accepted the byte by then, the ready SYNC 0000 comes after a fixed number of wait nibbles. That number is 3 for an I/O read, 2 for an I/O write, 3 for a DMA read and 4 for a DMA write. The ready SYNC never comes earlier than the clock after the handshake.
- R4: Wait nibbles inside the fixed wait are 0110 for I/O and 0101 for DMA. Wait nibbles beyond the fixed wait are always 0110.
- R5: `txn_valid` is high from the first SYNC clock until the handshake, the give-up point or an abort. Its payload stays stable until it is accepted, and it is low from the clock after the handshake.
- R6: If the byte is not accepted within the fixed wait and `rsp_long` is low, the block drives the error SYNC 1010 in the first clock after the fixed wait.
- R7: With `rsp_long` high, the block keeps driving 0110 while it waits. If the byte is still not accepted at SYNC clock 330 (counting from 0), it drives 1010 in that clock.
- R8: The error SYNC is 1010, driven when `rsp_err` comes with the handshake or on a timeout. On a read, two data nibbles still follow the error SYNC.
- R9: In the DMA size nibble, bits 1:0 select the byte count: 00 gives 1, 01 gives 2, 11 gives 4, and 10 gives 1. Each byte gets its own SYNC and data exchange. An error SYNC ends the cycle, and the remaining bytes are skipped.
- R10: The block turns the bus around in two clocks. It drives 1111 for one clock, then releases LAD. `lad_oe` is high only during SYNC, read data and that first turnaround clock, never while the host drives.
- R11: If the frame strobe goes low in the middle of a cycle, the block abandons the cycle. It releases LAD and drops `txn_valid` from the next clock, and it starts afresh if that nibble is 0000.
- R12: Reset is asynchronous and active low. While reset is held, `lad_oe` is low, `txn_valid` is low, `ldrq_n` is high and the frame strobe is ignored. `ldrq_n` stays high after reset as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Active-low frame strobe |
| lad_in | input | 4 | LAD nibble as seen on the bus |
| lad_out | output | 4 | Nibble this block drives |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| ldrq_n | output | 1 | Active-low DMA request, held inactive |
| txn_valid | output | 1 | Byte transaction offered to the register side |
| txn_ready | input | 1 | Register side accepts the transaction |
| txn_write | output | 1 | Host writes this byte |
| txn_dma | output | 1 | Byte belongs to a DMA cycle |
| txn_addr | output | ADDR_W | I/O address, or DMA channel zero-extended |
| txn_idx | output | 2 | Byte index within a DMA transfer |
| txn_wdata | output | 8 | Host write data |
| rsp_rdata | input | 8 | Read data, taken at the handshake |
| rsp_err | input | 1 | Error flag, taken at the handshake |
| rsp_long | input | 1 | Permit extended waiting up to the cap |

## Verification
Every combination of the four cycle kinds is tried with the register side answering at once, late within the fixed wait, and after it. The late-after case is tried both with and without extended waiting, which separates the ready, short-timeout and capped-timeout endings of the SYNC phase and the wait nibble code in each position. DMA sizes of 1, 2 and 4 bytes, with an error on the first or a middle byte, show whether later bytes are skipped and whether read nibbles still follow the error. Start nibbles other than 0000, foreign cycle types, strobe aborts in the address and SYNC phases, and a reset in mid-cycle show that the bus is released and idle afterwards.

// File: rtl/lpc_tgt_pkg.sv
`timescale 1ns/1ps
package lpc_tgt_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] NIB_START  = 4'h0;
  localparam logic [NIB_W-1:0] SYNC_READY = 4'h0;
  localparam logic [NIB_W-1:0] SYNC_SHORT = 4'h5;
  localparam logic [NIB_W-1:0] SYNC_LONG  = 4'h6;
  localparam logic [NIB_W-1:0] SYNC_ERR   = 4'hA;
  localparam logic [NIB_W-1:0] NIB_TAR    = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_CHAN, ST_SIZE,
    ST_WDATA, ST_HTAR, ST_SYNC, ST_RDATA, ST_TTAR
  } lpc_st_e;

  // size nibble bits 1:0 -> index of the last byte
  function automatic logic [1:0] size_last(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd1;
      2'b11:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lpc_sync_timer.sv
`timescale 1ns/1ps
module lpc_sync_timer #(
  parameter int LONG_MAX = 330,
  parameter int CNT_W    = $clog2(LONG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] wait_n,
  input  logic             done,
  input  logic             long_req,
  output logic [CNT_W-1:0] cnt,
  output logic             past_fixed,
  output logic             give_up,
  output logic             finish
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(LONG_MAX);

  assign past_fixed = cnt >= wait_n;
  assign give_up    = active && !done && past_fixed && (!long_req || cnt >= CAP);
  assign finish     = active && ((past_fixed && done) || give_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!active || finish)      cnt <= '0;
    else if (cnt != CAP)             cnt <= cnt + CNT_W'(1);
  end

  a_r7_wait_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt <= CAP);

  a_r6_giveup_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (active && give_up) |=> cnt == '0);

endmodule

// File: rtl/lpc_nibble_drive.sv
`timescale 1ns/1ps
module lpc_nibble_drive
  import lpc_tgt_pkg::*;
(
  input  lpc_st_e          st,
  input  logic             sub_lsb,
  input  logic             finish,
  input  logic             fin_err,
  input  logic             past_fixed,
  input  logic [NIB_W-1:0] wait_code,
  input  logic [7:0]       rdata,
  output logic [NIB_W-1:0] lad_out,
  output logic             lad_oe
);

  always_comb begin
    lad_out = NIB_TAR;
    lad_oe  = 1'b0;
    case (st)
      ST_SYNC: begin
        lad_oe = 1'b1;
        if (finish)          lad_out = fin_err ? SYNC_ERR : SYNC_READY;
        else if (past_fixed) lad_out = SYNC_LONG;
        else                 lad_out = wait_code;
      end
      ST_RDATA: begin
        lad_oe  = 1'b1;
        lad_out = sub_lsb ? rdata[7:4] : rdata[3:0];
      end
      ST_TTAR: begin
        lad_oe  = !sub_lsb;
        lad_out = NIB_TAR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpc_target.sv
`timescale 1ns/1ps
module lpc_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int IO_RD_WAIT    = 3,
  parameter int IO_WR_WAIT    = 2,
  parameter int DMA_RD_WAIT   = 3,
  parameter int DMA_WR_WAIT   = 4,
  parameter int LONG_WAIT_MAX = 330
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              ldrq_n,
  output logic              txn_valid,
  input  logic              txn_ready,
  output logic              txn_write,
  output logic              txn_dma,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [1:0]        txn_idx,
  output logic [7:0]        txn_wdata,
  input  logic [7:0]        rsp_rdata,
  input  logic              rsp_err,
  input  logic              rsp_long
);

  localparam int ADDR_NIB = ADDR_W / NIB_W;
  localparam int SUB_W    = (ADDR_NIB > 2) ? $clog2(ADDR_NIB) : 1;
  localparam int CNT_W    = $clog2(LONG_WAIT_MAX + 1);

  lpc_st_e           st;
  logic [SUB_W-1:0]  sub;
  logic              wr_q, dma_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        idx_q, last_idx;
  logic [7:0]        wdata_q, rdata_q;

  logic [CNT_W-1:0]  wait_n, sync_cnt;
  logic              in_sync, past_fixed, give_up, finish, hs, more_bytes;

  assign in_sync = (st == ST_SYNC);
  assign wait_n  = dma_q ? (wr_q ? CNT_W'(DMA_WR_WAIT) : CNT_W'(DMA_RD_WAIT))
                         : (wr_q ? CNT_W'(IO_WR_WAIT)  : CNT_W'(IO_RD_WAIT));

  lpc_sync_timer #(.LONG_MAX(LONG_WAIT_MAX), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(in_sync), .wait_n(wait_n),
    .done(done_q), .long_req(rsp_long), .cnt(sync_cnt),
    .past_fixed(past_fixed), .give_up(give_up), .finish(finish)
  );

  lpc_nibble_drive u_drive (
    .st(st), .sub_lsb(sub[0]), .finish(finish), .fin_err(give_up || err_q),
    .past_fixed(past_fixed), .wait_code(dma_q ? SYNC_SHORT : SYNC_LONG),
    .rdata(rdata_q), .lad_out(lad_out), .lad_oe(lad_oe)
  );

  assign txn_valid  = in_sync && !done_q && !give_up;
  assign hs         = txn_valid && txn_ready;
  assign more_bytes = dma_q && (idx_q != last_idx) && !err_q;
  assign txn_write  = wr_q;
  assign txn_dma    = dma_q;
  assign txn_addr   = addr_q;
  assign txn_idx    = idx_q;
  assign txn_wdata  = wdata_q;
  assign ldrq_n     = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  sub <= '0;  wr_q <= 1'b0;  dma_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; addr_q <= '0; idx_q <= '0;
      last_idx <= '0; wdata_q <= '0; rdata_q <= '0;
    end else if (!lframe_n) begin
      st     <= (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
      sub    <= '0;
      done_q <= 1'b0;
    end else begin
      case (st)
        ST_CTYPE: begin
          wr_q <= lad_in[1];  dma_q <= lad_in[3];
          err_q <= 1'b0;  idx_q <= '0;  last_idx <= '0;  addr_q <= '0;
          case (lad_in[3:2])
            2'b00:   st <= ST_ADDR;
            2'b10:   st <= ST_CHAN;
            default: st <= ST_IDLE;
          endcase
        end
        ST_ADDR: begin
          addr_q <= {addr_q[ADDR_W-NIB_W-1:0], lad_in};
          if (sub == SUB_W'(ADDR_NIB - 1)) begin
            sub <= '0;
            st  <= wr_q ? ST_WDATA : ST_HTAR;
          end else sub <= sub + SUB_W'(1);
        end
        ST_CHAN: begin
          addr_q <= ADDR_W'(lad_in);
          st     <= ST_SIZE;
        end
        ST_SIZE: begin
          last_idx <= size_last(lad_in[1:0]);
          st       <= wr_q ? ST_WDATA : ST_HTAR;
        end
        ST_WDATA: begin
          if (!sub[0]) begin wdata_q[3:0] <= lad_in; sub <= SUB_W'(1); end
          else begin wdata_q[7:4] <= lad_in; sub <= '0; st <= ST_HTAR; end
        end
        ST_HTAR: begin
          if (!sub[0]) sub <= SUB_W'(1);
          else begin sub <= '0; st <= ST_SYNC; err_q <= 1'b0; done_q <= 1'b0; end
        end
        ST_SYNC: begin
          if (hs) begin
            done_q  <= 1'b1;
            rdata_q <= rsp_rdata;
            err_q   <= rsp_err;
          end
          if (finish) begin
            done_q <= 1'b0;
            if (give_up) err_q <= 1'b1;
            sub <= '0;
            st  <= wr_q ? ST_TTAR : ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (!sub[0]) sub <= SUB_W'(1);
          else begin
            sub <= '0;
            if (more_bytes) begin idx_q <= idx_q + 2'd1; st <= ST_SYNC; end
            else st <= ST_TTAR;
          end
        end
        ST_TTAR: begin
          if (!sub[0]) sub <= SUB_W'(1);
          else begin
            sub <= '0;
            if (more_bytes && wr_q) begin idx_q <= idx_q + 2'd1; st <= ST_WDATA; end
            else st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> (!lad_oe && !txn_valid));

  a_r5_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> ($stable(txn_addr) && $stable(txn_wdata) &&
                                   $stable(txn_write) && $stable(txn_idx)));

  a_r3_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && sync_cnt < wait_n) |-> (lad_out != SYNC_READY));

  a_r8_data_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && lad_out == SYNC_ERR && !wr_q && lframe_n) |=> (st == ST_RDATA && lad_oe));

  a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> (idx_q <= last_idx));

  a_r10_release_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TTAR && !sub[0] && lframe_n) |=> !lad_oe);

endmodule

// File: tb/sim_lpc_target.sv
`timescale 1ns/1ps
module sim_lpc_target;

  localparam int LONG = 330;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe, ldrq_n, txn_valid, txn_write, txn_dma;
  logic        txn_ready = 1'b0;
  logic [15:0] txn_addr;
  logic [1:0]  txn_idx;
  logic [7:0]  txn_wdata;
  logic [7:0]  rsp_rdata = 8'h00;
  logic        rsp_err = 1'b0;
  logic        rsp_long = 1'b0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  lpc_target u0 (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .ldrq_n(ldrq_n),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_write(txn_write),
    .txn_dma(txn_dma), .txn_addr(txn_addr), .txn_idx(txn_idx),
    .txn_wdata(txn_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_long(rsp_long)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int wait_of(input bit wr, input bit dma);
    if (dma) return wr ? 4 : 3;
    return wr ? 2 : 3;
  endfunction

  function automatic int bytes_of(input logic [1:0] c);
    if (c == 2'b01) return 2;
    if (c == 2'b11) return 4;
    return 1;
  endfunction

  // host-driven clock: target must be silent and offer nothing
  task automatic host(input bit fr, input logic [3:0] n, input string req);
    @(negedge clk);
    chk(!lad_oe && !txn_valid, req, {lad_oe, txn_valid}, 0);
    lframe_n  = fr;
    lad_in    = n;
    txn_ready = 1'b0;
  endtask

  task automatic txn(input bit wr, input bit dma, input logic [15:0] a,
                     input logic [1:0] szc, input int dly, input int errb,
                     input bit lng);
    int n, nb, g, fin;
    logic [3:0] fcode, expn;
    logic [7:0] wd, rd;
    logic [15:0] ea;
    bit tmo, err;
    n  = wait_of(wr, dma);
    nb = dma ? bytes_of(szc) : 1;
    g  = lng ? LONG : n;
    ea = dma ? {12'h000, a[3:0]} : a;
    rsp_long = lng;
    host(1'b0, 4'h0, "R1 start");
    host(1'b1, {dma, 1'b0, wr, 1'($urandom)}, "R2 ctype");
    if (dma) begin
      host(1'b1, a[3:0], "R2 chan");
      host(1'b1, {2'b00, szc}, "R9 size");
    end else begin
      for (int i = 0; i < 4; i++) host(1'b1, a[15-4*i -: 4], "R2 addr");
    end
    for (int b = 0; b < nb; b++) begin
      wd = 8'($urandom);
      rd = 8'($urandom);
      if (wr) begin
        host(1'b1, wd[3:0], "R2 wdata");
        host(1'b1, wd[7:4], "R2 wdata");
      end
      if (wr || b == 0) begin
        host(1'b1, 4'hF, "R10 host tar");
        host(1'b1, 4'hF, "R10 host tar");
      end
      if (dly < g) begin
        tmo = 1'b0;
        fin = (dly + 1 > n) ? dly + 1 : n;
        fcode = (b == errb) ? 4'hA : 4'h0;
      end else begin
        tmo = 1'b1;
        fin = g;
        fcode = 4'hA;
      end
      for (int k = 0; k <= fin; k++) begin
        @(negedge clk);
        txn_ready = 1'b0;
        chk(lad_oe == 1'b1, "R10 sync oe", lad_oe, 1);
        if (k < fin) begin
          expn = (k < n) ? (dma ? 4'h5 : 4'h6) : 4'h6;
          chk(lad_out == expn, "R4 wait code", lad_out, expn);
        end else begin
          chk(lad_out == fcode, tmo ? (lng ? "R7 capped timeout" : "R6 short timeout")
                                    : (fcode == 4'hA ? "R8 error sync" : "R3 ready sync"),
              lad_out, fcode);
          chk(txn_valid == 1'b0, "R5 valid dropped", txn_valid, 0);
        end
        if (!tmo && k == dly) begin
          chk(txn_valid == 1'b1, "R5 valid", txn_valid, 1);
          chk(txn_write == wr && txn_dma == dma, "R2 kind", {txn_write, txn_dma}, {wr, dma});
          chk(txn_addr == ea, "R2 address", txn_addr, ea);
          chk(txn_idx == 2'(b), "R9 byte index", txn_idx, b);
          if (wr) chk(txn_wdata == wd, "R2 write data", txn_wdata, wd);
          txn_ready = 1'b1;
          rsp_rdata = rd;
          rsp_err   = (b == errb);
        end
      end
      err = (fcode == 4'hA);
      if (!wr) begin
        for (int j = 0; j < 2; j++) begin
          @(negedge clk);
          txn_ready = 1'b0;
          chk(lad_oe == 1'b1, "R8 read nibble driven", lad_oe, 1);
          if (!tmo) begin
            expn = j ? rd[7:4] : rd[3:0];
            chk(lad_out == expn, err ? "R8 data after error" : "R2 read data",
                lad_out, expn);
          end
        end
      end else begin
        @(negedge clk);
        txn_ready = 1'b0;
        chk(lad_oe && lad_out == 4'hF, "R10 tar drive", {lad_oe, lad_out}, 5'h1F);
        @(negedge clk);
        chk(!lad_oe, "R10 tar release", lad_oe, 0);
      end
      if (err) break;
    end
    if (!wr) begin
      @(negedge clk);
      chk(lad_oe && lad_out == 4'hF, "R10 tar drive", {lad_oe, lad_out}, 5'h1F);
      @(negedge clk);
      chk(!lad_oe, "R10 tar release", lad_oe, 0);
    end
    @(negedge clk);
    chk(!lad_oe && !txn_valid, "R9 idle after cycle", {lad_oe, txn_valid}, 0);
    rsp_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R12: frame strobe with START nibble ignored under reset
    lframe_n = 1'b0;
    lad_in   = 4'h0;
    repeat (3) begin
      @(negedge clk);
      chk(!lad_oe && !txn_valid && ldrq_n, "R12 reset state",
          {lad_oe, txn_valid, ldrq_n}, 1);
    end
    lframe_n = 1'b1;
    lad_in   = 4'h2;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) host(1'b1, 4'(i), "R12 no cycle after reset");

    // directed main cases, R3
    txn(1'b1, 1'b0, 16'h1234, 2'b00, 0, -1, 1'b0);
    txn(1'b0, 1'b0, 16'hBEEF, 2'b00, 0, -1, 1'b0);
    txn(1'b0, 1'b1, 16'h0005, 2'b01, 1, -1, 1'b0);
    txn(1'b1, 1'b1, 16'h0003, 2'b11, 2, -1, 1'b0);
    txn(1'b1, 1'b1, 16'h0002, 2'b10, 3, -1, 1'b0);
    // R6 short timeout, R7 extended and capped
    txn(1'b0, 1'b0, 16'h03F8, 2'b00, 5, -1, 1'b0);
    txn(1'b0, 1'b0, 16'h0378, 2'b00, 10, -1, 1'b1);
    txn(1'b1, 1'b0, 16'h0278, 2'b00, 400, -1, 1'b1);
    // R8 error on read, R9 error in multi-byte DMA
    txn(1'b0, 1'b0, 16'h0060, 2'b00, 1, 0, 1'b0);
    txn(1'b1, 1'b1, 16'h0001, 2'b11, 0, 0, 1'b0);
    txn(1'b0, 1'b1, 16'h0006, 2'b11, 0, 1, 1'b0);

    // R1: non-zero START ignored
    host(1'b0, 4'h2, "R1 bad start");
    for (int i = 0; i < 8; i++) host(1'b1, 4'h0, "R1 bad start ignored");
    // R2: foreign cycle type ignored
    host(1'b0, 4'h0, "R2 start");
    host(1'b1, 4'h4, "R2 memory type");
    for (int i = 0; i < 10; i++) host(1'b1, 4'hF, "R2 foreign type ignored");

    // R11: abort in address phase, then restart
    host(1'b0, 4'h0, "R11 start");
    host(1'b1, 4'h0, "R11 ctype");
    host(1'b1, 4'h1, "R11 addr");
    host(1'b0, 4'h5, "R11 abort nibble");
    for (int i = 0; i < 6; i++) host(1'b1, 4'h0, "R11 idle after abort");
    host(1'b0, 4'h0, "R11 start");
    host(1'b1, 4'h2, "R11 ctype");
    txn(1'b0, 1'b0, 16'h4321, 2'b00, 0, -1, 1'b0);

    // R11: abort during SYNC
    host(1'b0, 4'h0, "R11 start");
    host(1'b1, 4'h0, "R11 ctype");
    for (int i = 0; i < 4; i++) host(1'b1, 4'h8, "R11 addr");
    host(1'b1, 4'hF, "R11 tar");
    host(1'b1, 4'hF, "R11 tar");
    @(negedge clk);
    chk(lad_oe && txn_valid, "R11 in sync", {lad_oe, txn_valid}, 3);
    lframe_n = 1'b0;
    lad_in   = 4'h5;
    @(negedge clk);
    chk(!lad_oe && !txn_valid, "R11 sync abort release", {lad_oe, txn_valid}, 0);
    lframe_n = 1'b1;
    for (int i = 0; i < 4; i++) host(1'b1, 4'h0, "R11 idle");

    // R12: reset in mid-cycle
    host(1'b0, 4'h0, "R12 start");
    host(1'b1, 4'h0, "R12 ctype");
    for (int i = 0; i < 4; i++) host(1'b1, 4'h8, "R12 addr");
    host(1'b1, 4'hF, "R12 tar");
    host(1'b1, 4'hF, "R12 tar");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!lad_oe && !txn_valid && ldrq_n, "R12 async reset release",
        {lad_oe, txn_valid, ldrq_n}, 1);
    lframe_n = 1'b0;
    lad_in   = 4'h0;
    @(negedge clk);
    lframe_n = 1'b1;
    lad_in   = 4'h0;
    rst_n    = 1'b1;
    for (int i = 0; i < 6; i++) host(1'b1, 4'h0, "R12 idle after reset");

    // constrained random mix
    for (int r = 0; r < 40; r++) begin
      bit wr, dma, lng;
      int dly, errb;
      wr   = 1'($urandom);
      dma  = 1'($urandom);
      lng  = 1'($urandom);
      dly  = int'($urandom % 6);
      errb = ($urandom % 4 == 0) ? int'($urandom % 4) : -1;
      txn(wr, dma, 16'($urandom), 2'($urandom), dly, errb, lng);
    end
    chk(ldrq_n == 1'b1, "R12 request inactive", ldrq_n, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule